// File: doc/BRIEF.md
# Atomic Compare-Swap Resource Bank

This block keeps four 32-bit bus-management words that change only through an atomic compare-and-swap. A host stages the operation in three registers: it places the new value in a data register, then the expected value in a compare register. Writing a resource selector into a control register then launches the swap. When the swap finishes, a done flag is set and the data register holds the resource's prior contents.

A serial-bus request port reaches the same words independently of the host. Only two request kinds are accepted on this port: a quadlet read and a quadlet lock (compare-and-swap). Any other kind receives a type-error code. An offset outside the four resource addresses receives an address-error code. A successful lock produces a response, and the link must acknowledge it. When that acknowledge is not "complete", the block raises a one-cycle lock-response-error event.

A fixed-priority arbiter serialises both requesters and favours the bus. Each granted request runs its read-compare-write as one uninterrupted sequence. A hardware reset or a bus reset reloads all four words with their initial values.

Top module: `cas_resource_bank`

## Requirements
- R1: After `rst`, selectors 0..3 (bus manager ID, bandwidth available, channels-available high, channels-available low) hold 0x0000003F, 0x00001333, 0xFFFFFFFF and 0xFFFFFFFF, and the host control register reads 0.
- R2: A one-cycle `bus_reset` pulse reloads all four words with the R1 values.
- R3: Host address 0 is the data register, 1 is compare, and 2 is control (selector in bits 1:0, done in bit 31). A control write starts a swap: if the selected word equals compare, it takes the data value, and in either case the data register receives the old word and done is set.
- R4: When the selected word differs from compare, it is left unchanged. No path exists that changes a word except a matching compare-and-swap or a reset.
- R5: Any control write clears done. Control bits 30:2 read as zero, and writing bit 31 never sets done.
- R6: A bus quadlet read (kind 0) returns the selected word with code 0 and leaves it unchanged.
- R7: A bus quadlet lock (kind 1) swaps under the same compare rule, answers with code 0 and the old word, and needs no host action.
- R8: A bus kind other than 0 or 1 is answered with code 1 (type error) and data 0, and no word changes. This check comes before the offset check.
- R9: Bus offsets 0x21C, 0x220, 0x224 and 0x228 select words 0..3. Any other offset, misaligned ones included, is answered with code 2 (address error).
- R10: After a code-0 lock response, the next `link_ack_valid` with `link_ack_complete` low pulses `lock_resp_err` for one cycle. A complete acknowledge leaves it low.
- R11: When a bus request and a pending host swap compete, the bus goes first. The host swap runs only after the bus sequence, acknowledge included, has ended.
- R12: A bus response appears exactly two cycles after the request is accepted and lasts one cycle. With the bank idle, done is set two cycles after the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_reset | input | 1 | Reloads the four resource words |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_addr | input | 2 | Host write address (0 data, 1 compare, 2 control) |
| host_wr_data | input | 32 | Host write data |
| host_rd_addr | input | 2 | Host read address |
| host_rd_data | output | 32 | Host read data (combinational) |
| bus_req_valid | input | 1 | Bus request present |
| bus_req_ready | output | 1 | Bank idle, request accepted this cycle |
| bus_req_kind | input | 3 | 0 quadlet read, 1 quadlet lock, others illegal |
| bus_req_offset | input | 12 | Low address offset of the request |
| bus_req_arg | input | 32 | Lock compare value |
| bus_req_data | input | 32 | Lock new value |
| bus_rsp_valid | output | 1 | One-cycle response strobe |
| bus_rsp_code | output | 2 | 0 complete, 1 type error, 2 address error |
| bus_rsp_data | output | 32 | Old or current word, 0 on error |
| link_ack_valid | input | 1 | Acknowledge for a lock response |
| link_ack_complete | input | 1 | Acknowledge was "complete" |
| lock_resp_err | output | 1 | One-cycle lock-response-error event |

## Verification
The hardest situation to reach is a true collision: a control write and a bus lock on the same word arriving on the same clock edge. The host swap must then wait through the bus response and its acknowledge, and only afterwards see the word the bus wrote. The bench drives both strobes on one falling edge. It chains the host compare value to the bus lock's new value, so the host swap succeeds only if the order was bus first. A missing "complete" acknowledge is forced directly on the link input after a successful lock.

// File: rtl/cas_bank_pkg.sv
package cas_bank_pkg;

    localparam int WORD_W  = 32;
    localparam int NUM_RES = 4;
    localparam int SEL_W   = $clog2(NUM_RES);
    localparam int OFF_W   = 12;
    localparam int KIND_W  = 3;

    localparam logic [KIND_W-1:0] KIND_QREAD = 3'd0;
    localparam logic [KIND_W-1:0] KIND_QLOCK = 3'd1;

    typedef enum logic [1:0] {
        RSP_COMPLETE = 2'd0,
        RSP_TYPE_ERR = 2'd1,
        RSP_ADDR_ERR = 2'd2
    } rsp_code_e;

    typedef enum logic [1:0] {
        HREG_DATA = 2'd0,
        HREG_CMP  = 2'd1,
        HREG_CTRL = 2'd2
    } hreg_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_ACK  = 2'd2
    } fsm_e;

    typedef struct packed {
        logic               from_bus;
        logic               is_lock;
        logic [SEL_W-1:0]   sel;
        rsp_code_e          status;
        logic [WORD_W-1:0]  cmp;
        logic [WORD_W-1:0]  nval;
    } cas_op_t;

    typedef struct packed {
        logic             hit;
        logic [SEL_W-1:0] sel;
    } addr_dec_t;

    function automatic logic [WORD_W-1:0] res_reset_value(input int unsigned idx);
        case (idx)
            0:       return 32'h0000_003F;
            1:       return 32'h0000_1333;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic addr_dec_t decode_offset(input logic [OFF_W-1:0] off,
                                                input logic [OFF_W-1:0] base);
        addr_dec_t        d;
        logic [OFF_W-1:0] rel;
        rel   = off - base;
        d.hit = (off >= base) && (rel[1:0] == 2'b00) &&
                (rel[OFF_W-1:2] < (OFF_W-2)'(NUM_RES));
        d.sel = rel[SEL_W+1:2];
        return d;
    endfunction

endpackage

// File: rtl/cas_res_store.sv
module cas_res_store
    import cas_bank_pkg::*;
#(
    parameter int N = NUM_RES,
    parameter int W = WORD_W,
    localparam int SW = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_reset,
    input  logic         swap_en,
    input  logic [SW-1:0] swap_sel,
    input  logic [W-1:0]  swap_val,
    output logic [N*W-1:0] res_flat
);
    for (genvar i = 0; i < N; i++) begin : g_word
        logic [W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst || bus_reset)
                word_q <= W'(res_reset_value(i));
            else if (swap_en && swap_sel == SW'(i))
                word_q <= swap_val;
        end
        assign res_flat[i*W +: W] = word_q;
    end
endmodule

// File: rtl/cas_fixed_arb.sv
module cas_fixed_arb #(
    parameter int N = 2
) (
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        gnt = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (en && req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/cas_host_regs.sv
module cas_host_regs
    import cas_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              taken,
    input  logic              complete,
    input  logic [WORD_W-1:0] old_val,
    output logic [WORD_W-1:0] data_q,
    output logic [WORD_W-1:0] cmp_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic              pending_q,
    output logic              done_q
);
    always_ff @(posedge clk) begin
        if (complete)
            data_q <= old_val;
        else if (wr_en && wr_addr == HREG_DATA)
            data_q <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (wr_en && wr_addr == HREG_CMP)
            cmp_q <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= '0;
            pending_q <= 1'b0;
            done_q    <= 1'b0;
        end else if (wr_en && wr_addr == HREG_CTRL) begin
            sel_q     <= wr_data[SEL_W-1:0];
            pending_q <= 1'b1;
            done_q    <= 1'b0;
        end else begin
            if (taken)
                pending_q <= 1'b0;
            if (complete)
                done_q <= 1'b1;
        end
    end

    always_comb begin
        case (rd_addr)
            HREG_DATA: rd_data = data_q;
            HREG_CMP:  rd_data = cmp_q;
            HREG_CTRL: rd_data = {done_q, {(WORD_W-1-SEL_W){1'b0}}, sel_q};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cas_resource_bank.sv
module cas_resource_bank
    import cas_bank_pkg::*;
#(
    parameter logic [OFF_W-1:0] OFFSET_BASE = 12'h21C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_reset,
    input  logic              host_wr_en,
    input  logic [1:0]        host_wr_addr,
    input  logic [WORD_W-1:0] host_wr_data,
    input  logic [1:0]        host_rd_addr,
    output logic [WORD_W-1:0] host_rd_data,
    input  logic              bus_req_valid,
    output logic              bus_req_ready,
    input  logic [KIND_W-1:0] bus_req_kind,
    input  logic [OFF_W-1:0]  bus_req_offset,
    input  logic [WORD_W-1:0] bus_req_arg,
    input  logic [WORD_W-1:0] bus_req_data,
    output logic              bus_rsp_valid,
    output logic [1:0]        bus_rsp_code,
    output logic [WORD_W-1:0] bus_rsp_data,
    input  logic              link_ack_valid,
    input  logic              link_ack_complete,
    output logic              lock_resp_err
);
    localparam int GNT_BUS  = 0;
    localparam int GNT_HOST = 1;

    fsm_e                     state_q;
    cas_op_t                  op_q, bus_op, host_op;
    addr_dec_t                dec;
    logic [NUM_RES*WORD_W-1:0] res_flat;
    logic [WORD_W-1:0]        res_arr [NUM_RES];
    logic [WORD_W-1:0]        old_val;
    logic [1:0]               gnt;
    logic                     swap_en, host_complete, host_taken;
    logic [WORD_W-1:0]        h_data, h_cmp;
    logic [SEL_W-1:0]         h_sel;
    logic                     host_pending, host_done;
    rsp_code_e                rsp_code_q;

    for (genvar i = 0; i < NUM_RES; i++) begin : g_view
        assign res_arr[i] = res_flat[i*WORD_W +: WORD_W];
    end

    assign old_val       = res_arr[op_q.sel];
    assign bus_req_ready = (state_q == ST_IDLE);
    assign host_taken    = gnt[GNT_HOST];
    assign host_complete = (state_q == ST_EXEC) && !op_q.from_bus;
    assign swap_en       = (state_q == ST_EXEC) && op_q.is_lock &&
                           (op_q.status == RSP_COMPLETE) && (old_val == op_q.cmp);
    assign bus_rsp_code  = rsp_code_q;

    cas_fixed_arb #(.N(2)) u_arb (
        .en  (state_q == ST_IDLE),
        .req ({host_pending, bus_req_valid}),
        .gnt (gnt)
    );

    cas_res_store #(.N(NUM_RES), .W(WORD_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .bus_reset(bus_reset),
        .swap_en  (swap_en),
        .swap_sel (op_q.sel),
        .swap_val (op_q.nval),
        .res_flat (res_flat)
    );

    cas_host_regs u_host (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (host_wr_en),
        .wr_addr  (host_wr_addr),
        .wr_data  (host_wr_data),
        .rd_addr  (host_rd_addr),
        .rd_data  (host_rd_data),
        .taken    (host_taken),
        .complete (host_complete),
        .old_val  (old_val),
        .data_q   (h_data),
        .cmp_q    (h_cmp),
        .sel_q    (h_sel),
        .pending_q(host_pending),
        .done_q   (host_done)
    );

    always_comb begin
        dec             = decode_offset(bus_req_offset, OFFSET_BASE);
        bus_op.from_bus = 1'b1;
        bus_op.is_lock  = (bus_req_kind == KIND_QLOCK);
        bus_op.sel      = dec.sel;
        bus_op.cmp      = bus_req_arg;
        bus_op.nval     = bus_req_data;
        if (bus_req_kind != KIND_QREAD && bus_req_kind != KIND_QLOCK)
            bus_op.status = RSP_TYPE_ERR;
        else if (!dec.hit)
            bus_op.status = RSP_ADDR_ERR;
        else
            bus_op.status = RSP_COMPLETE;

        host_op.from_bus = 1'b0;
        host_op.is_lock  = 1'b1;
        host_op.sel      = h_sel;
        host_op.status   = RSP_COMPLETE;
        host_op.cmp      = h_cmp;
        host_op.nval     = h_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q       <= ST_IDLE;
            op_q          <= '0;
            bus_rsp_valid <= 1'b0;
            rsp_code_q    <= RSP_COMPLETE;
            bus_rsp_data  <= '0;
            lock_resp_err <= 1'b0;
        end else begin
            bus_rsp_valid <= 1'b0;
            lock_resp_err <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (gnt[GNT_BUS]) begin
                        op_q    <= bus_op;
                        state_q <= ST_EXEC;
                    end else if (gnt[GNT_HOST]) begin
                        op_q    <= host_op;
                        state_q <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    if (op_q.from_bus) begin
                        bus_rsp_valid <= 1'b1;
                        rsp_code_q    <= op_q.status;
                        bus_rsp_data  <= (op_q.status == RSP_COMPLETE) ? old_val : '0;
                        state_q       <= (op_q.is_lock && op_q.status == RSP_COMPLETE)
                                         ? ST_ACK : ST_IDLE;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_ACK: begin
                    if (link_ack_valid) begin
                        lock_resp_err <= !link_ack_complete;
                        state_q       <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cas_resource_bank_chk.sv
module cas_resource_bank_chk
    import cas_bank_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_reset,
    input logic                      bus_req_valid,
    input logic                      bus_req_ready,
    input logic                      bus_rsp_valid,
    input logic [1:0]                bus_rsp_code,
    input logic                      link_ack_valid,
    input logic                      link_ack_complete,
    input logic                      lock_resp_err,
    input logic                      host_done,
    input fsm_e                      state_q,
    input logic [NUM_RES*WORD_W-1:0] res_flat
);
    AST_RSP_TWO_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (bus_req_valid && bus_req_ready) |=> ##1 bus_rsp_valid); // R12
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        bus_rsp_valid |=> !bus_rsp_valid); // R12
    AST_ERR_NEEDS_BAD_ACK: assert property (@(posedge clk) disable iff (rst)
        lock_resp_err |-> $past(link_ack_valid && !link_ack_complete)); // R10
    AST_ERR_RSP_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (bus_rsp_valid && bus_rsp_code != 2'd0 && !$past(bus_reset)) |-> $stable(res_flat)); // R8
    AST_CHANGE_ONLY_BY_SWAP: assert property (@(posedge clk) disable iff (rst)
        !$stable(res_flat) |-> ($past(state_q) == ST_EXEC || $past(bus_reset))); // R4
    AST_DONE_AFTER_EXEC: assert property (@(posedge clk) disable iff (rst)
        $rose(host_done) |-> ($past(state_q) == ST_EXEC)); // R3
endmodule

bind cas_resource_bank cas_resource_bank_chk u_chk (.*);

// File: tb/cas_resource_bank_tb.sv
module cas_resource_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_DATA = 2'd0, A_CMP = 2'd1, A_CTRL = 2'd2;

    logic        clk = 1'b0;
    logic        rst, bus_reset;
    logic        host_wr_en;
    logic [1:0]  host_wr_addr, host_rd_addr;
    logic [31:0] host_wr_data, host_rd_data;
    logic        bus_req_valid, bus_req_ready;
    logic [2:0]  bus_req_kind;
    logic [11:0] bus_req_offset;
    logic [31:0] bus_req_arg, bus_req_data;
    logic        bus_rsp_valid;
    logic [1:0]  bus_rsp_code;
    logic [31:0] bus_rsp_data;
    logic        link_ack_valid, link_ack_complete, lock_resp_err;

    int errors = 0;
    int checks = 0;
    logic [31:0] model [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    cas_resource_bank u_dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] off_of(input int s);
        return 12'h21C + 12'(4 * s);
    endfunction

    task automatic host_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_addr = a; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [31:0] d);
        host_rd_addr = a;
        #1 d = host_rd_data;
    endtask

    task automatic host_cas(input int s, input logic [31:0] cmp, input logic [31:0] nv, input string tag);
        logic [31:0] v;
        logic [31:0] old;
        old = model[s];
        host_wr(A_DATA, nv);
        host_wr(A_CMP, cmp);
        host_wr(A_CTRL, 32'(s));
        host_rd(A_CTRL, v); check({tag, " R12 done low one cycle after start"}, v[31], 1'b0);
        @(negedge clk);
        host_rd(A_CTRL, v); check({tag, " R12 done low before exec"}, v[31], 1'b0);
        @(negedge clk);
        host_rd(A_CTRL, v); check({tag, " R3 done set"}, v, {1'b1, 29'b0, 2'(s)});
        host_rd(A_DATA, v); check({tag, " R3 data holds old"}, v, old);
        if (old == cmp) model[s] = nv;
    endtask

    task automatic bus_op(input logic [2:0] kind, input logic [11:0] off,
                          input logic [31:0] cmp, input logic [31:0] nv,
                          input logic ack_ok, input logic [1:0] exp_code,
                          input logic [31:0] exp_data, input string tag);
        @(negedge clk);
        bus_req_valid = 1'b1; bus_req_kind = kind; bus_req_offset = off;
        bus_req_arg = cmp; bus_req_data = nv;
        while (!bus_req_ready) @(negedge clk);
        @(negedge clk);
        bus_req_valid = 1'b0;
        check({tag, " R12 no early response"}, 32'(bus_rsp_valid), 32'd0);
        @(negedge clk);
        check({tag, " R12 response valid"}, 32'(bus_rsp_valid), 32'd1);
        check({tag, " code"}, 32'(bus_rsp_code), 32'(exp_code));
        check({tag, " data"}, bus_rsp_data, exp_data);
        if (kind == 3'd1 && exp_code == 2'd0) begin
            link_ack_valid = 1'b1; link_ack_complete = ack_ok;
            @(negedge clk);
            link_ack_valid = 1'b0;
            check({tag, " R10 lock_resp_err"}, 32'(lock_resp_err), ack_ok ? 32'd0 : 32'd1);
        end else begin
            @(negedge clk);
            check({tag, " R10 no error event"}, 32'(lock_resp_err), 32'd0);
        end
    endtask

    task automatic read_all(input string tag);
        for (int s = 0; s < 4; s++)
            bus_op(3'd0, off_of(s), 32'd0, 32'd0, 1'b1, 2'd0, model[s], tag);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        model[0] = 32'h3F; model[1] = 32'h1333; model[2] = 32'hFFFF_FFFF; model[3] = 32'hFFFF_FFFF;
        host_rd(A_CTRL, v); check("R1 control reads zero", v, 32'd0);
        check("R1 no response after reset", 32'(bus_rsp_valid), 32'd0);
        read_all("R1 reset value");
    endtask

    task automatic t_host;
        logic [31:0] v;
        host_cas(0, 32'h3F, 32'h05, "R3 match");
        bus_op(3'd0, off_of(0), 0, 0, 1'b1, 2'd0, 32'h05, "R3 stored");
        host_cas(1, 32'h0, 32'h1, "R4 mismatch");
        bus_op(3'd0, off_of(1), 0, 0, 1'b1, 2'd0, 32'h1333, "R4 unchanged");
        host_wr(A_CTRL, 32'h7FFF_FFFE);
        host_rd(A_CTRL, v); check("R5 write clears done, reserved zero", v, 32'h2);
        @(negedge clk); @(negedge clk);
        host_rd(A_CTRL, v); check("R5 done after reserved-bit write", v, 32'h8000_0002);
        host_rd(A_DATA, v); check("R4 old word returned", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_bus;
        bus_op(3'd0, off_of(1), 0, 0, 1'b1, 2'd0, 32'h1333, "R6 read");
        bus_op(3'd0, off_of(1), 0, 0, 1'b1, 2'd0, 32'h1333, "R6 read unchanged");
        bus_op(3'd1, off_of(3), 32'hFFFF_FFFF, 32'hFFFF_0FFF, 1'b1, 2'd0, 32'hFFFF_FFFF, "R7 lock match");
        model[3] = 32'hFFFF_0FFF;
        bus_op(3'd1, off_of(3), 32'h0, 32'h1, 1'b1, 2'd0, 32'hFFFF_0FFF, "R7 lock mismatch");
        bus_op(3'd0, off_of(3), 0, 0, 1'b1, 2'd0, 32'hFFFF_0FFF, "R7 result");
        bus_op(3'd4, off_of(1), 32'h1333, 32'h0, 1'b1, 2'd1, 32'h0, "R8 illegal kind");
        bus_op(3'd2, 12'h400, 0, 0, 1'b1, 2'd1, 32'h0, "R8 type before address");
        bus_op(3'd0, off_of(1), 0, 0, 1'b1, 2'd0, 32'h1333, "R8 word unchanged");
        bus_op(3'd0, 12'h22C, 0, 0, 1'b1, 2'd2, 32'h0, "R9 offset past end");
        bus_op(3'd1, 12'h21E, 32'h05, 32'h9, 1'b1, 2'd2, 32'h0, "R9 misaligned");
        bus_op(3'd0, 12'h218, 0, 0, 1'b1, 2'd2, 32'h0, "R9 offset below base");
        bus_op(3'd1, off_of(0), 32'h05, 32'h06, 1'b0, 2'd0, 32'h05, "R10 missing ack");
        model[0] = 32'h06;
        bus_op(3'd0, off_of(0), 0, 0, 1'b1, 2'd0, 32'h06, "R10 swap kept");
    endtask

    task automatic t_priority;
        logic [31:0] v;
        host_wr(A_DATA, 32'h2000);
        host_wr(A_CMP, 32'h1000);
        @(negedge clk);
        bus_req_valid = 1'b1; bus_req_kind = 3'd1; bus_req_offset = off_of(1);
        bus_req_arg = 32'h1333; bus_req_data = 32'h1000;
        host_wr_en = 1'b1; host_wr_addr = A_CTRL; host_wr_data = 32'd1;
        @(negedge clk);
        bus_req_valid = 1'b0; host_wr_en = 1'b0;
        @(negedge clk);
        check("R11 bus served first", 32'(bus_rsp_valid), 32'd1);
        check("R11 bus sees original word", bus_rsp_data, 32'h1333);
        link_ack_valid = 1'b1; link_ack_complete = 1'b1;
        @(negedge clk);
        link_ack_valid = 1'b0;
        @(negedge clk);
        host_rd(A_CTRL, v); check("R11 host still waiting", v[31], 1'b0);
        @(negedge clk);
        host_rd(A_CTRL, v); check("R11 host done after bus", v[31], 1'b1);
        host_rd(A_DATA, v); check("R11 host sees bus value", v, 32'h1000);
        model[1] = 32'h2000;
        bus_op(3'd0, off_of(1), 0, 0, 1'b1, 2'd0, 32'h2000, "R11 host swap applied");
    endtask

    task automatic t_bus_reset;
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
        model[0] = 32'h3F; model[1] = 32'h1333; model[2] = 32'hFFFF_FFFF; model[3] = 32'hFFFF_FFFF;
        read_all("R2 bus reset value");
    endtask

    initial begin
        rst = 1'b1; bus_reset = 1'b0;
        host_wr_en = 1'b0; host_wr_addr = '0; host_wr_data = '0; host_rd_addr = '0;
        bus_req_valid = 1'b0; bus_req_kind = '0; bus_req_offset = '0;
        bus_req_arg = '0; bus_req_data = '0;
        link_ack_valid = 1'b0; link_ack_complete = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_host();
        t_bus();
        t_priority();
        t_bus_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule